// File: doc/BRIEF.md
# Static Memory Data-Float Wait Scheduler

This block sequences read and write accesses to asynchronous static memories on several chip selects. A request names a chip select and a direction. The block then takes the access through three counted phases: a setup phase with the chip select low, a strobe pulse phase with the read or write strobe low, and a hold phase with the strobe released. Each chip select has its own phase counts, float count and optimization flag. All of them are taken from the configuration inputs of the selected chip select.

A memory that has just been read keeps driving the data bus for a programmed number of float cycles after its read strobe rises. The block counts this time from the end of the read strobe, so the read hold phase uses it up. In the non-optimized mode, any float cycles still left when the hold ends are added to the read access itself. In the optimized mode, the read finishes at once and the next access absorbs the remaining float time. The idle cycle, the chip-select gap and the setup phase of the next access all count toward it. Extra wait cycles are inserted before the next strobe only for the float cycles still missing.

The scheduler sits between a requester and the external bus pins. The requester holds `req_valid` until the block leaves its idle state. It then sees `done` on the last cycle of the access.

Top module: `smc_float_sched`

States: `ST_IDLE` (accepts a request), `ST_GAP` (one dead cycle on a chip-select change), `ST_SETUP`, `ST_WAIT` (float wait before the strobe), `ST_PULSE`, `ST_HOLD`, `ST_FLOAT` (non-optimized float tail). Transitions:
- IDLE to GAP on a chip-select change, otherwise IDLE to SETUP.
- GAP to SETUP.
- SETUP to WAIT or PULSE, depending on whether float time is still pending.
- WAIT to PULSE once the float count expires.
- PULSE to HOLD.
- HOLD to FLOAT for a non-optimized read with float cycles left, otherwise HOLD to IDLE.
- FLOAT to IDLE.
- A phase with a count of zero is skipped. The next state is then chosen as if that phase had ended.

## Requirements
- R1: While reset is held, all `cs_n` bits, `rd_n` and `wr_n` are 1, and `busy` and `done` are 0.
- R2: Take the cycle in which a request is accepted as cycle 0. The strobe first goes low in cycle 1 + G + S + W, where G is the gap, S the setup count of the selected chip select and W the float wait. A setup count of 0 adds no cycle. The strobe stays low for the pulse count, and a pulse count of 0 acts as 1.
- R3: G is one cycle, with every `cs_n` bit high, when the chip select differs from that of the previous access. G is zero for the same chip select and for the first access after reset.
- R4: After a read on a chip select whose optimization flag is 0, `done` comes max(0, F − H) cycles after the last hold cycle. Here F is that chip select's float count and H its hold count.
- R5: After a read on a chip select whose optimization flag is 1, the next access's W is max(0, F − H − 1 − G − S). Its own G and S are used. This applies to a write on any chip select and to a read on another chip select.
- R6: A read that follows a read on the same chip select has W = 0.
- R7: `done` is high for exactly one cycle, on the final cycle of the access, and `busy` is high in that cycle.
- R8: Only the `cs_n` bit of the addressed chip select goes low, from the first setup cycle to the last hold cycle. `rd_n` goes low only for reads and `wr_n` only for writes (`req_write` = 1 selects a write). Both strobes are never low together.
- R9: `req_valid` is only taken in the idle state. Changing request fields while `busy` is high does not affect the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_cs | input | $clog2(NUM_CS) | Chip select of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_setup | input | NUM_CS*CNT_W | Setup cycles, field i for chip select i |
| cfg_pulse | input | NUM_CS*CNT_W | Strobe pulse cycles per chip select |
| cfg_hold | input | NUM_CS*CNT_W | Hold cycles per chip select |
| cfg_float | input | NUM_CS*CNT_W | Data float cycles per chip select |
| cfg_opt | input | NUM_CS | Float optimization flag per chip select |
| busy | output | 1 | High outside the idle state |
| done | output | 1 | Final cycle of an access |
| cs_n | output | NUM_CS | Registered chip selects, active low |
| rd_n | output | 1 | Registered read strobe, active low |
| wr_n | output | 1 | Registered write strobe, active low |

## Verification
Each access produces two results, both measured from the accept cycle. The first is the lead: the cycle of the first low strobe, due 1 + G + S + W cycles after acceptance. The second is the tail: the cycle of `done`, due pulse + hold + float-tail cycles after the strobe starts. The driver computes both from the requirement formulas and queues them. The monitor samples every falling edge, counts cycles from the accept edge, and compares against the queue head when the strobe and `done` appear. Inputs change just after a rising edge, so the falling-edge samples never race the design's registers.

// File: rtl/smc_fw_pkg.sv
package smc_fw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SETUP,
        ST_WAIT,
        ST_PULSE,
        ST_HOLD,
        ST_FLOAT
    } smc_state_e;
endpackage

// File: rtl/smc_fw_cfg_pick.sv
module smc_fw_cfg_pick #(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 4
) (
    input  logic [$clog2(NUM_CS)-1:0]   sel,
    input  logic [NUM_CS*CNT_W-1:0]     setup_all,
    input  logic [NUM_CS*CNT_W-1:0]     pulse_all,
    input  logic [NUM_CS*CNT_W-1:0]     hold_all,
    input  logic [NUM_CS*CNT_W-1:0]     float_all,
    input  logic [NUM_CS-1:0]           opt_all,
    output logic [CNT_W-1:0]            setup,
    output logic [CNT_W-1:0]            pulse,
    output logic [CNT_W-1:0]            hold,
    output logic [CNT_W-1:0]            flt,
    output logic                        opt
);
    logic [CNT_W-1:0] s_arr [NUM_CS];
    logic [CNT_W-1:0] p_arr [NUM_CS];
    logic [CNT_W-1:0] h_arr [NUM_CS];
    logic [CNT_W-1:0] f_arr [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
        assign s_arr[g] = setup_all[g*CNT_W +: CNT_W];
        assign p_arr[g] = pulse_all[g*CNT_W +: CNT_W];
        assign h_arr[g] = hold_all[g*CNT_W +: CNT_W];
        assign f_arr[g] = float_all[g*CNT_W +: CNT_W];
    end

    assign setup = s_arr[sel];
    assign pulse = p_arr[sel];
    assign hold  = h_arr[sel];
    assign flt   = f_arr[sel];
    assign opt   = opt_all[sel];
endmodule

// File: rtl/smc_fw_float_timer.sv
module smc_fw_float_timer #(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [CNT_W-1:0]            load_val,
    input  logic [$clog2(NUM_CS)-1:0]   load_cs,
    input  logic                        load_opt,
    output logic [CNT_W-1:0]            cnt_q,
    output logic [CNT_W-1:0]            cnt_dec,
    output logic [$clog2(NUM_CS)-1:0]   owner_cs,
    output logic                        owner_opt
);
    assign cnt_dec = (cnt_q != '0) ? cnt_q - 1'b1 : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            owner_cs  <= '0;
            owner_opt <= 1'b0;
        end else if (load) begin
            cnt_q     <= load_val;
            owner_cs  <= load_cs;
            owner_opt <= load_opt;
        end else begin
            cnt_q     <= cnt_dec;
        end
    end

    AST_FLOAT_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/smc_float_sched.sv
module smc_float_sched #(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [$clog2(NUM_CS)-1:0]   req_cs,
    input  logic                        req_write,
    input  logic [NUM_CS*CNT_W-1:0]     cfg_setup,
    input  logic [NUM_CS*CNT_W-1:0]     cfg_pulse,
    input  logic [NUM_CS*CNT_W-1:0]     cfg_hold,
    input  logic [NUM_CS*CNT_W-1:0]     cfg_float,
    input  logic [NUM_CS-1:0]           cfg_opt,
    output logic                        busy,
    output logic                        done,
    output logic [NUM_CS-1:0]           cs_n,
    output logic                        rd_n,
    output logic                        wr_n
);
    import smc_fw_pkg::*;

    localparam int CS_W = $clog2(NUM_CS);

    smc_state_e         state_q, state_d;
    logic [CNT_W-1:0]   pcnt_q, pcnt_d;
    logic [CS_W-1:0]    cur_cs_q;
    logic               cur_wr_q;
    logic               have_last_q;

    logic [CS_W-1:0]    sel_cs;
    logic               sel_wr;
    logic [CNT_W-1:0]   c_setup, c_pulse, c_hold, c_flt;
    logic               c_opt;

    logic               flt_load;
    logic [CNT_W-1:0]   flt_cnt, flt_dec, rem;
    logic [CS_W-1:0]    owner_cs;
    logic               owner_opt;
    logic               blocked;
    logic               accept;
    logic               active_d;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign sel_cs = (state_q == ST_IDLE) ? req_cs    : cur_cs_q;
    assign sel_wr = (state_q == ST_IDLE) ? req_write : cur_wr_q;

    smc_fw_cfg_pick #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) i_pick (
        .sel       (sel_cs),
        .setup_all (cfg_setup),
        .pulse_all (cfg_pulse),
        .hold_all  (cfg_hold),
        .float_all (cfg_float),
        .opt_all   (cfg_opt),
        .setup     (c_setup),
        .pulse     (c_pulse),
        .hold      (c_hold),
        .flt       (c_flt),
        .opt       (c_opt)
    );

    smc_fw_float_timer #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (flt_load),
        .load_val  (c_flt),
        .load_cs   (cur_cs_q),
        .load_opt  (c_opt),
        .cnt_q     (flt_cnt),
        .cnt_dec   (flt_dec),
        .owner_cs  (owner_cs),
        .owner_opt (owner_opt)
    );

    // Float time still owed by another device before a strobe may start
    assign blocked = (flt_dec != '0) && !(!sel_wr && (sel_cs == owner_cs));
    // Float cycles left once the current read has ended its hold
    assign rem     = (state_q == ST_PULSE) ? c_flt : flt_dec;

    always_comb begin
        logic go_setup, go_strobe, go_hold, go_end;
        state_d   = state_q;
        pcnt_d    = pcnt_q;
        flt_load  = 1'b0;
        done      = 1'b0;
        go_setup  = 1'b0;
        go_strobe = 1'b0;
        go_hold   = 1'b0;
        go_end    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (have_last_q && (req_cs != cur_cs_q)) state_d = ST_GAP;
                    else                                    go_setup = 1'b1;
                end
            end
            ST_GAP:   go_setup = 1'b1;
            ST_SETUP: begin
                if (pcnt_q == '0) go_strobe = 1'b1;
                else              pcnt_d = pcnt_q - 1'b1;
            end
            ST_WAIT: begin
                if (!blocked) go_strobe = 1'b1;
            end
            ST_PULSE: begin
                if (pcnt_q == '0) begin
                    flt_load = !cur_wr_q;
                    go_hold  = 1'b1;
                end else begin
                    pcnt_d = pcnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (pcnt_q == '0) go_end = 1'b1;
                else              pcnt_d = pcnt_q - 1'b1;
            end
            ST_FLOAT: begin
                if (flt_dec == '0) begin
                    done    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (go_setup) begin
            if (c_setup != '0) begin
                state_d = ST_SETUP;
                pcnt_d  = c_setup - 1'b1;
            end else begin
                go_strobe = 1'b1;
            end
        end
        if (go_strobe) begin
            if (blocked) begin
                state_d = ST_WAIT;
            end else begin
                state_d = ST_PULSE;
                pcnt_d  = (c_pulse == '0) ? '0 : c_pulse - 1'b1;
            end
        end
        if (go_hold) begin
            if (c_hold != '0) begin
                state_d = ST_HOLD;
                pcnt_d  = c_hold - 1'b1;
            end else begin
                go_end = 1'b1;
            end
        end
        if (go_end) begin
            if (!cur_wr_q && !c_opt && (rem != '0)) begin
                state_d = ST_FLOAT;
            end else begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pcnt_q      <= '0;
            cur_cs_q    <= '0;
            cur_wr_q    <= 1'b0;
            have_last_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
            if (accept) begin
                cur_cs_q    <= req_cs;
                cur_wr_q    <= req_write;
                have_last_q <= 1'b1;
            end
        end
    end

    assign active_d = (state_d == ST_SETUP) || (state_d == ST_WAIT) ||
                      (state_d == ST_PULSE) || (state_d == ST_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n <= '1;
            rd_n <= 1'b1;
            wr_n <= 1'b1;
        end else begin
            for (int i = 0; i < NUM_CS; i++) begin
                cs_n[i] <= !(active_d && (sel_cs == CS_W'(i)));
            end
            rd_n <= !((state_d == ST_PULSE) && !sel_wr);
            wr_n <= !((state_d == ST_PULSE) && sel_wr);
        end
    end

    assign busy = (state_q != ST_IDLE);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R8
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R8
    AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (cs_n != '1)); // R8
    AST_GAP_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (cs_n == '1)); // R3
    AST_NO_EARLY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && $past(state_q) != ST_PULSE) |->
        (flt_cnt == '0 || (!cur_wr_q && cur_cs_q == owner_cs))); // R5
    AST_NOPT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !owner_opt) |-> (flt_cnt == '0)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
endmodule

// File: tb/test_smc_float_sched.sv
module test_smc_float_sched;
    localparam int NCS = 4;
    localparam int CW  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_cs = '0;
    logic             req_write = 1'b0;
    logic [NCS*CW-1:0] cfg_setup, cfg_pulse, cfg_hold, cfg_float;
    logic [NCS-1:0]   cfg_opt;
    logic             busy, done, rd_n, wr_n;
    logic [NCS-1:0]   cs_n;

    always #5 clk = ~clk;

    smc_float_sched #(.NUM_CS(NCS), .CNT_W(CW)) i_smc_float_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
        .req_write(req_write), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
        .cfg_hold(cfg_hold), .cfg_float(cfg_float), .cfg_opt(cfg_opt),
        .busy(busy), .done(done), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    int c_s [NCS] = '{3, 3, 0, 1};
    int c_p [NCS] = '{2, 2, 0, 1};
    int c_h [NCS] = '{4, 4, 0, 1};
    int c_f [NCS] = '{6, 6, 3, 9};
    int c_o [NCS] = '{1, 0, 1, 1};

    typedef struct {
        int    cs;
        int    wr;
        int    lead;
        int    tail;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Bench model of the previous access
    bit have_prev = 1'b0;
    int prev_cs, prev_rd, prev_opt, prev_f, prev_h;

    task automatic do_access(input int cs, input int wr, input string tag);
        exp_t e;
        int g, w, pe;
        g = (have_prev && cs != prev_cs) ? 1 : 0;
        w = 0;
        if (have_prev && prev_rd == 1 && prev_opt == 1 && !(wr == 0 && cs == prev_cs)) begin
            w = prev_f - prev_h - 1 - g - c_s[cs];
            if (w < 0) w = 0;
        end
        pe = (c_p[cs] == 0) ? 1 : c_p[cs];
        e.cs   = cs;
        e.wr   = wr;
        e.lead = 1 + g + c_s[cs] + w;
        e.tail = pe + c_h[cs] +
                 ((wr == 0 && c_o[cs] == 0 && c_f[cs] > c_h[cs]) ? c_f[cs] - c_h[cs] : 0);
        e.tag  = tag;
        exp_q.push_back(e);
        have_prev = 1'b1;
        prev_cs   = cs;
        prev_rd   = (wr == 0) ? 1 : 0;
        prev_opt  = c_o[cs];
        prev_f    = c_f[cs];
        prev_h    = c_h[cs];
        // R9: new fields appear while the previous access is still busy
        req_cs    = 2'(cs);
        req_write = (wr != 0);
        req_valid = 1'b1;
        do @(negedge clk); while (busy);
        @(posedge clk);
        #1;
    endtask

    // Monitor: measures lead and tail of each access from the accept cycle
    bit mon_on = 1'b0;
    bit seen   = 1'b0;
    int cnt, lead_obs, tail_obs, cs_obs, wr_obs;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mon_on) begin
                if (!seen) begin
                    cnt++;
                    if (!rd_n || !wr_n) begin
                        seen     = 1'b1;
                        lead_obs = cnt;
                        tail_obs = 0;
                        wr_obs   = !wr_n ? 1 : 0;
                        cs_obs   = -1;
                        for (int i = 0; i < NCS; i++) if (!cs_n[i]) cs_obs = i;
                    end
                end
                if (seen) begin
                    tail_obs++;
                    if (done) begin
                        exp_t e;
                        mon_on = 1'b0;
                        if (exp_q.size() == 0) begin
                            check("R2", "unexpected access", 1, 0);
                        end else begin
                            e = exp_q.pop_front();
                            check("R8", {e.tag, " chip select"}, cs_obs, e.cs);
                            check("R8", {e.tag, " direction"}, wr_obs, e.wr);
                            check(e.tag, "strobe lead", lead_obs, e.lead);
                            check((e.wr == 0 && c_o[e.cs] == 0) ? "R4" : "R2",
                                  {e.tag, " strobe to done"}, tail_obs, e.tail);
                            check("R7", {e.tag, " busy at done"}, busy ? 1 : 0, 1);
                        end
                    end
                end
            end
            if (req_valid && !busy) begin
                mon_on = 1'b1;
                seen   = 1'b0;
                cnt    = 0;
            end
        end
    end

    initial begin
        for (int i = 0; i < NCS; i++) begin
            cfg_setup[i*CW +: CW] = CW'(c_s[i]);
            cfg_pulse[i*CW +: CW] = CW'(c_p[i]);
            cfg_hold[i*CW +: CW]  = CW'(c_h[i]);
            cfg_float[i*CW +: CW] = CW'(c_f[i]);
            cfg_opt[i]            = (c_o[i] != 0);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "cs_n in reset", int'(cs_n), 15);
        check("R1", "rd_n in reset", int'(rd_n), 1);
        check("R1", "wr_n in reset", int'(wr_n), 1);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "done in reset", int'(done), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        do_access(0, 0, "R2 R9 first read");
        do_access(0, 1, "R5 write after read same cs, hold+setup cover float");
        do_access(1, 0, "R3 read on new cs");
        do_access(1, 1, "R4 write after non-optimized read");
        do_access(3, 0, "R3 read cs3");
        do_access(3, 0, "R6 read after read same cs");
        do_access(2, 0, "R5 read other cs, six wait cycles");
        do_access(2, 1, "R5 write same cs, hold zero");
        do_access(0, 1, "R3 write after write");
        do_access(2, 0, "R2 zero setup and pulse");
        do_access(2, 0, "R6 zero-setup read after read");
        do_access(0, 0, "R5 float already expired");
        do_access(1, 0, "R4 non-optimized read");
        do_access(0, 0, "R4 read after non-optimized read");
        req_valid = 1'b0;

        repeat (40) @(negedge clk);
        check("R2", "accesses left unfinished", exp_q.size(), 0);
        check("R7", "busy after last access", int'(busy), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule